// File: doc/BRIEF.md
# Fault Record Collector with Summary

This block gathers fault reports from a large set of safety mechanisms and files each one into a per-block error record. A record keeps the first fault it accepts: whether the fault could be corrected, which mechanism raised it, and a primary error code. It keeps that fault until software clears it. A summary vector holds one bit per record. The block also reports the lowest-numbered record that is in error, which is the next record software should service.

Faults arrive one per cycle as a record number, a mechanism ID, an uncorrectable flag and a code. Before a fault is logged, three conditions must hold: its mechanism is switched on for that record, the record's detection enable is set, and, for a corrected fault, the record's corrected-error enable is set. Mechanisms are switched on or off through one packed write. That write can also act on every mechanism of a block at once, which silences blocks that are absent. Two interrupt lines, one for corrected faults and one for uncorrectable faults, are built from the valid records and each record's interrupt enables. All access uses a flat register port: a write strobe, an address, write data, and combinational read data.

Top module: `fault_record_hub`

## Requirements
- R1: Address 0x000 reads the record count NUM_REC in bits [15:0], with all other bits zero.
- R2: Summary word k is at address 0x010+k. Its bit i is the valid flag of record 32k+i, so the word reads zero when no record in that range is in error.
- R3: svc_valid is high when any record is valid. svc_rec then gives the lowest-numbered valid record.
- R4: The status of record r reads at address 0x201+2r as: [31] valid, [30] uncorrectable, [23:16] mechanism ID, [7:0] error code, with all other bits zero. The whole word reads zero while the record is not valid.
- R5: An accepted fault makes its record valid in the cycle after it is presented, and stores the fault's uncorrectable flag, mechanism ID and code. When no fault is presented, no record becomes valid.
- R6: A status write with bit 31 set clears the record. A status write with bit 31 clear has no effect. While a record is valid, later faults to it leave its stored fields unchanged.
- R7: When a fault to a record is accepted in the same cycle as that record's clear, the fault wins: the record stays valid and holds the new fault's fields.
- R8: The control word of record r is at address 0x200+2r. Its bits are [0] detection enable, [1] corrected-error enable, [2] corrected interrupt enable and [3] uncorrectable interrupt enable. It reads back as written and resets to zero. Faults are ignored while bit 0 is clear, and corrected faults are ignored while bit 1 is clear.
- R9: A write to address 0x001 sets the enable of one mechanism (ID in [15:8]) of one record (in [23:16]) to bit [0]. When bit [1] is set, the write applies to all mechanisms of that record instead. All mechanisms reset disabled. Faults from a disabled mechanism, an out-of-range record or an out-of-range mechanism ID are ignored.
- R10: irq_ce is high when any valid corrected record has its corrected interrupt enable set. irq_ue is high when any valid uncorrectable record has its uncorrectable interrupt enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_valid | input | 1 | Fault report present this cycle |
| flt_rec | input | RECW | Record (block) the fault belongs to |
| flt_sm | input | SMW | Mechanism ID that raised the fault |
| flt_ue | input | 1 | Fault is uncorrectable |
| flt_code | input | 8 | Primary error code |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_ce | output | 1 | Corrected-error interrupt |
| irq_ue | output | 1 | Uncorrectable-error interrupt |
| svc_valid | output | 1 | Some record is in error |
| svc_rec | output | RECW | Lowest-numbered record in error |

## Verification
The bench builds the block with six records and four mechanisms per record. At that size every record and mechanism pair can be visited. For each pair the bench captures a fault, refuses an overwrite, ignores a status write without the clear bit, clears, and then confirms the mechanism is silenced once disabled. The small record count also lets a single summary word and the three-bit service index cover out-of-range record numbers. In the same run the bench exercises interrupt gating, a clear colliding with a fault, and whole-block disable.

// File: rtl/fault_record_hub.sv
module fault_record_hub #(
  parameter int NUM_REC = 44,
  parameter int NUM_SM  = 34,
  localparam int RECW = (NUM_REC > 1) ? $clog2(NUM_REC) : 1,
  localparam int SMW  = (NUM_SM > 1) ? $clog2(NUM_SM) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flt_valid,
  input  logic [RECW-1:0] flt_rec,
  input  logic [SMW-1:0]  flt_sm,
  input  logic            flt_ue,
  input  logic [7:0]      flt_code,
  input  logic            reg_we,
  input  logic [9:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            irq_ce,
  output logic            irq_ue,
  output logic            svc_valid,
  output logic [RECW-1:0] svc_rec
);
  localparam int GW = (NUM_REC + 31) / 32;

  logic [NUM_REC-1:0] vld, ue_q, ci_en, ui_en;
  logic [SMW-1:0]     ierr_q [NUM_REC];
  logic [7:0]         code_q [NUM_REC];
  logic [3:0]         ctl_q  [NUM_REC];
  logic [NUM_SM-1:0]  smen_q [NUM_REC];
  logic [GW*32-1:0]   gsr_pad;

  wire       smen_we  = reg_we && (reg_addr == 10'h001);
  wire [7:0] smen_blk = reg_wdata[23:16];
  wire [7:0] smen_sm  = reg_wdata[15:8];
  wire       smen_all = reg_wdata[1];
  wire       smen_en  = reg_wdata[0];
  wire       rec_sel  = reg_addr[9];
  wire [7:0] ridx     = reg_addr[8:1];
  wire       in_range = flt_valid && (32'(flt_rec) < NUM_REC) && (32'(flt_sm) < NUM_SM);

  for (genvar r = 0; r < NUM_REC; r++) begin : g_rec
    logic hit, clr, cwe;
    assign hit = in_range && (flt_rec == RECW'(r)) && smen_q[r][flt_sm] &&
                 ctl_q[r][0] && (flt_ue || ctl_q[r][1]);
    assign clr = reg_we && rec_sel && reg_addr[0] && (ridx == 8'(r)) && reg_wdata[31];
    assign cwe = reg_we && rec_sel && !reg_addr[0] && (ridx == 8'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld[r]    <= 1'b0;
        ue_q[r]   <= 1'b0;
        ierr_q[r] <= '0;
        code_q[r] <= '0;
      end else if (hit && (!vld[r] || clr)) begin
        vld[r]    <= 1'b1;
        ue_q[r]   <= flt_ue;
        ierr_q[r] <= flt_sm;
        code_q[r] <= flt_code;
      end else if (clr) begin
        vld[r]    <= 1'b0;
        ue_q[r]   <= 1'b0;
        ierr_q[r] <= '0;
        code_q[r] <= '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q[r] <= '0;
      else if (cwe) ctl_q[r] <= reg_wdata[3:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smen_q[r] <= '0;
      else if (smen_we && smen_blk == 8'(r)) begin
        for (int m = 0; m < NUM_SM; m++)
          if (smen_all || smen_sm == 8'(m)) smen_q[r][m] <= smen_en;
      end
    end

    assign ci_en[r] = ctl_q[r][2];
    assign ui_en[r] = ctl_q[r][3];
  end

  assign gsr_pad = (GW*32)'(vld);
  assign irq_ce  = |(vld & ~ue_q & ci_en);
  assign irq_ue  = |(vld & ue_q & ui_en);

  always_comb begin
    svc_valid = 1'b0;
    svc_rec   = '0;
    for (int i = NUM_REC - 1; i >= 0; i--) begin
      if (vld[i]) begin
        svc_valid = 1'b1;
        svc_rec   = RECW'(i);
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 10'h000) begin
      reg_rdata = {16'b0, 16'(NUM_REC)};
    end else if (reg_addr[9:4] == 6'h01) begin
      if (32'(reg_addr[3:0]) < GW) reg_rdata = gsr_pad[{reg_addr[3:0], 5'b0} +: 32];
    end else if (rec_sel) begin
      for (int r = 0; r < NUM_REC; r++) begin
        if (ridx == 8'(r))
          reg_rdata = reg_addr[0] ? {vld[r], ue_q[r], 6'b0, 8'(ierr_q[r]), 8'b0, code_q[r]}
                                  : {28'b0, ctl_q[r]};
      end
    end
  end
endmodule

// File: rtl/fault_record_hub_chk.sv
module fault_record_hub_chk #(
  parameter int NUM_REC = 44,
  parameter int RECW = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flt_valid,
  input logic               reg_we,
  input logic [9:0]         reg_addr,
  input logic [31:0]        reg_wdata,
  input logic [31:0]        reg_rdata,
  input logic [NUM_REC-1:0] vld,
  input logic               irq_ce,
  input logic               irq_ue,
  input logic               svc_valid,
  input logic [RECW-1:0]    svc_rec
);
  assert_id_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 10'h000) |-> (reg_rdata == 32'(NUM_REC)));

  assert_svc_points_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> vld[svc_rec]);

  assert_svc_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !svc_valid |-> (vld == '0));

  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_valid |=> ($countones(vld) <= $countones($past(vld))));

  assert_irq_needs_record_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ce || irq_ue) |-> (vld != '0));

  for (genvar r = 0; r < NUM_REC; r++) begin : g_hold
    assert_hold_until_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (vld[r] && !(reg_we && reg_addr == 10'(10'h201 + 2 * r) && reg_wdata[31])) |=> vld[r]);
  end
endmodule

bind fault_record_hub fault_record_hub_chk #(.NUM_REC(NUM_REC), .RECW(RECW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vld(vld),
  .irq_ce(irq_ce), .irq_ue(irq_ue), .svc_valid(svc_valid), .svc_rec(svc_rec)
);

// File: tb/fault_record_hub_tb.sv
module fault_record_hub_tb;
  localparam int NR = 6;
  localparam int NS = 4;

  logic clk = 0, rst_n = 0;
  logic flt_valid = 0, flt_ue = 0, reg_we = 0;
  logic [2:0] flt_rec = 0;
  logic [1:0] flt_sm = 0;
  logic [7:0] flt_code = 0;
  logic [9:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq_ce, irq_ue, svc_valid;
  logic [2:0] svc_rec;
  int checks = 0, errors = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  fault_record_hub #(.NUM_REC(NR), .NUM_SM(NS)) u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    reg_we = 0; flt_valid = 0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d; tick();
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic flt(input int r, input int s, input logic ue, input logic [7:0] c);
    flt_valid = 1; flt_rec = 3'(r); flt_sm = 2'(s); flt_ue = ue; flt_code = c; tick();
  endtask

  function automatic logic [31:0] sts(input logic ue, input int s, input logic [7:0] c);
    return {1'b1, ue, 6'b0, 8'(s), 8'b0, c};
  endfunction

  function automatic logic [31:0] smw(input int r, input int s, input logic en, input logic all);
    return {8'b0, 8'(r), 8'(s), 6'b0, all, en};
  endfunction

  function automatic logic [9:0] ca(input int r); return 10'(10'h200 + 2 * r); endfunction
  function automatic logic [9:0] sa(input int r); return 10'(10'h201 + 2 * r); endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(10'h000, rv); check("R1 id", rv, 32'd6);
    rd(10'h010, rv); check("R2 summary reset", rv, 0);
    rd(10'h011, rv); check("R2 unused summary word", rv, 0);
    check("R3 svc reset", {31'b0, svc_valid}, 0);
    check("R10 irq reset", {30'b0, irq_ce, irq_ue}, 0);
    rd(ca(0), rv); check("R8 ctrl reset", rv, 0);
    rd(sa(0), rv); check("R4 status reset", rv, 0);

    wr(ca(0), 32'h3);
    flt(0, 0, 1, 8'h11);
    rd(10'h010, rv); check("R9 mechanism off ignored", rv, 0);
    wr(10'h001, smw(0, 0, 1, 0));
    wr(ca(0), 32'h2);
    rd(ca(0), rv); check("R8 ctrl readback", rv, 32'h2);
    flt(0, 0, 1, 8'h11);
    rd(10'h010, rv); check("R8 detect off ignored", rv, 0);
    flt(6, 0, 1, 8'h11);
    flt(7, 3, 1, 8'h11);
    rd(10'h010, rv); check("R9 out-of-range record ignored", rv, 0);

    for (int r = 0; r < NR; r++) begin
      for (int s = 0; s < NS; s++) begin
        logic [7:0] c;
        c = 8'(r * 16 + s + 1);
        wr(ca(r), 32'h3);
        wr(10'h001, smw(r, s, 1, 0));
        flt(r, s, s[0], c);
        rd(10'h010, rv); check("R2 summary bit", rv, 32'(1 << r));
        check("R3 svc index", {28'b0, svc_valid, svc_rec}, {28'b0, 1'b1, 3'(r)});
        rd(sa(r), rv); check("R5 R4 status capture", rv, sts(s[0], s, c));
        flt(r, s, ~s[0], 8'hEE);
        rd(sa(r), rv); check("R6 no overwrite", rv, sts(s[0], s, c));
        wr(sa(r), 32'h7FFF_FFFF);
        rd(sa(r), rv); check("R6 write without clear bit", rv, sts(s[0], s, c));
        wr(sa(r), sts(s[0], s, c));
        rd(10'h010, rv); check("R6 clear", rv, 0);
        rd(sa(r), rv); check("R4 status cleared", rv, 0);
        wr(10'h001, smw(r, s, 0, 0));
        flt(r, s, 1, c);
        rd(10'h010, rv); check("R9 mechanism disabled", rv, 0);
      end
    end

    wr(ca(2), 32'h1);
    wr(10'h001, smw(2, 0, 1, 1));
    flt(2, 3, 0, 8'h21);
    rd(10'h010, rv); check("R8 corrected off ignored", rv, 0);
    flt(2, 3, 1, 8'h22);
    rd(sa(2), rv); check("R8 R9 uncorrectable with all enabled", rv, sts(1, 3, 8'h22));
    wr(sa(2), 32'h8000_0000);

    wr(ca(1), 32'h3);
    wr(10'h001, smw(1, 1, 1, 0));
    flt(1, 1, 0, 8'hA1);
    flt_valid = 1; flt_rec = 1; flt_sm = 1; flt_ue = 1; flt_code = 8'hB2;
    reg_we = 1; reg_addr = sa(1); reg_wdata = 32'h8000_0000; tick();
    rd(sa(1), rv); check("R7 fault beats clear", rv, sts(1, 1, 8'hB2));

    wr(ca(3), 32'h3); wr(10'h001, smw(3, 2, 1, 0));
    wr(ca(4), 32'h3); wr(10'h001, smw(4, 0, 1, 0));
    flt(4, 0, 1, 8'h40);
    flt(3, 2, 0, 8'h30);
    rd(10'h010, rv); check("R2 multiple", rv, 32'b011010);
    check("R3 lowest of three", {28'b0, svc_valid, svc_rec}, {28'b0, 4'b1001});
    wr(sa(1), 32'h8000_0000);
    check("R3 next lowest", {28'b0, svc_valid, svc_rec}, {28'b0, 4'b1011});
    wr(ca(3), 32'h7);
    check("R10 corrected irq", {30'b0, irq_ce, irq_ue}, 32'b10);
    wr(sa(3), 32'h8000_0000);
    check("R3 last", {28'b0, svc_valid, svc_rec}, {28'b0, 4'b1100});
    check("R10 no irq without enable", {30'b0, irq_ce, irq_ue}, 0);
    wr(ca(4), 32'hB);
    check("R10 uncorrectable irq", {30'b0, irq_ce, irq_ue}, 32'b01);
    wr(ca(4), 32'h7);
    check("R10 ue record ignores ce enable", {30'b0, irq_ce, irq_ue}, 0);
    wr(sa(4), 32'h8000_0000);

    wr(ca(5), 32'h3);
    wr(10'h001, smw(5, 0, 1, 1));
    wr(10'h001, smw(5, 0, 0, 1));
    for (int s = 0; s < NS; s++) flt(5, s, 1, 8'h55);
    rd(10'h010, rv); check("R9 block disable all", rv, 0);
    check("R3 idle", {31'b0, svc_valid}, 0);

    finish_run();
  end
endmodule